// File: doc/BRIEF.md
# Condition Code Evaluator

A purely combinational gate that decides whether an instruction is allowed to take effect. It reads a 4-bit condition code from the instruction and checks it against the four arithmetic flags (negative, zero, carry, overflow) held in the status word. The result is a single `pass_o` line that the execute stage uses to commit or squash the instruction.

Two instruction formats are accepted, chosen by `half_mode_i`. A full-width word carries its condition in the top nibble. A 16-bit halfword carries it in bits 11:8. Only halfword branches are conditional, so a halfword that is not a branch always passes. The all-ones code is reserved: it raises `err_o` and holds `pass_o` low. Flag generation and decode beyond the condition field belong to other blocks.

Top module: `cond_gate`

## Requirements
- R1: Flags are read from the status word at these positions: N at bit 31, Z at bit 30, C at bit 29, V at bit 28. All other status bits have no effect.
- R2: Codes 0 to 7 test one flag each: 0 passes on Z, 1 on !Z, 2 on C, 3 on !C, 4 on N, 5 on !N, 6 on V, 7 on !V.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N==V. Code 11 passes when N!=V.
- R5: Code 12 passes when Z=0 and N==V. Code 13 passes when Z=1 or N!=V.
- R6: Code 14 passes for every flag value, with `err_o` low.
- R7: Code 15 drives `err_o` high and `pass_o` low whenever the condition applies.
- R8: With `half_mode_i`=0 the code is bits 31:28 of `instr_i`. Bits 27:0 and `is_branch_i` have no effect.
- R9: With `half_mode_i`=1 and `is_branch_i`=1 the code is bits 11:8 of `instr_i`. Bits 31:16 have no effect.
- R10: With `half_mode_i`=1 and `is_branch_i`=0, `pass_o`=1 and `err_o`=0 for every code and flag value.
- R11: `pass_o` and `err_o` are never high together, and both follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word. A halfword sits in bits 15:0. |
| half_mode_i | input | 1 | 1 selects the 16-bit format. |
| is_branch_i | input | 1 | In 16-bit format, marks the halfword as a conditional branch. |
| status_i | input | 32 | Status word that holds the N, Z, C and V flags. |
| pass_o | output | 1 | The instruction is allowed to execute. |
| err_o | output | 1 | The condition code is the reserved value. |

## Verification
Every code is swept against all sixteen flag combinations in both formats. This exposes a swapped flag position, an inverted odd code or a mixed-up signed/unsigned pair, each of which shows up as a pass on the wrong flag pattern. Junk is placed in the unused instruction and status bits to catch a field taken from the wrong nibble. In the 16-bit format a design that failed to ignore the upper bits would pick up the wrong code. Non-branch halfwords carrying code 15 catch a design that raises the error or suppresses instructions whose condition does not apply. Such a design would squash ordinary halfword arithmetic.

// File: rtl/cond_pkg.sv
package cond_pkg;
  typedef enum logic [3:0] {
    C_EQ, C_NE, C_CS, C_CC, C_MI, C_PL, C_VS, C_VC,
    C_HI, C_LS, C_GE, C_LT, C_GT, C_LE, C_AL, C_NV
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_field_sel.sv
module cond_field_sel #(
  parameter int INSTR_W    = 32,
  parameter int CODE_W     = 4,
  parameter int WIDE_LSB   = 28,
  parameter int NARROW_LSB = 8
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               half_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int WIDE_MSB   = WIDE_LSB + CODE_W - 1;
  localparam int NARROW_MSB = NARROW_LSB + CODE_W - 1;

  always_comb begin
    if (half_i) code_o = instr_i[NARROW_MSB:NARROW_LSB];
    else        code_o = instr_i[WIDE_MSB:WIDE_LSB];
  end
endmodule

// File: rtl/flag_unpack.sv
module flag_unpack
  import cond_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int N_POS    = 31,
  parameter int Z_POS    = 30,
  parameter int C_POS    = 29,
  parameter int V_POS    = 28
) (
  input  logic [STATUS_W-1:0] status_i,
  output flags_t              flags_o
);
  assign flags_o.n = status_i[N_POS];
  assign flags_o.z = status_i[Z_POS];
  assign flags_o.c = status_i[C_POS];
  assign flags_o.v = status_i[V_POS];
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  cond_e  code_i,
  input  flags_t flags_i,
  output logic   pass_o,
  output logic   rsv_o
);
  logic base;

  // Even code tests the condition, odd code tests its inverse.
  always_comb begin
    unique case (code_i[3:1])
      3'd0:    base = flags_i.z;
      3'd1:    base = flags_i.c;
      3'd2:    base = flags_i.n;
      3'd3:    base = flags_i.v;
      3'd4:    base = flags_i.c & ~flags_i.z;
      3'd5:    base = ~(flags_i.n ^ flags_i.v);
      3'd6:    base = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
      default: base = 1'b1;
    endcase
  end

  always_comb begin
    rsv_o = (code_i == C_NV);
    if (code_i[3:1] == 3'd7) pass_o = ~code_i[0];
    else                     pass_o = base ^ code_i[0];
  end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int STATUS_W = 32
) (
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                half_mode_i,
  input  logic                is_branch_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                pass_o,
  output logic                err_o
);
  localparam int CODE_W = $bits(cond_e);

  logic [CODE_W-1:0] code_w;
  flags_t            flags_w;
  logic              pass_w, rsv_w, applies_w;

  cond_field_sel #(
    .INSTR_W(INSTR_W), .CODE_W(CODE_W),
    .WIDE_LSB(INSTR_W - CODE_W), .NARROW_LSB(8)
  ) u_sel (
    .instr_i(instr_i), .half_i(half_mode_i), .code_o(code_w)
  );

  flag_unpack #(
    .STATUS_W(STATUS_W), .N_POS(STATUS_W - 1), .Z_POS(STATUS_W - 2),
    .C_POS(STATUS_W - 3), .V_POS(STATUS_W - 4)
  ) u_flags (
    .status_i(status_i), .flags_o(flags_w)
  );

  cond_eval u_eval (
    .code_i(cond_e'(code_w)), .flags_i(flags_w), .pass_o(pass_w), .rsv_o(rsv_w)
  );

  // Halfwords are conditional only when they are branches.
  assign applies_w = ~half_mode_i | is_branch_i;
  assign pass_o    = applies_w ? pass_w : 1'b1;
  assign err_o     = applies_w & rsv_w;
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk #(
  parameter int INSTR_W  = 32,
  parameter int STATUS_W = 32
) (
  input logic [INSTR_W-1:0]  instr_i,
  input logic                half_mode_i,
  input logic                is_branch_i,
  input logic [STATUS_W-1:0] status_i,
  input logic                pass_o,
  input logic                err_o
);
  logic [3:0] code_c;
  logic       known_c;

  assign code_c  = half_mode_i ? instr_i[11:8] : instr_i[INSTR_W-1:INSTR_W-4];
  assign known_c = !$isunknown({instr_i, half_mode_i, is_branch_i, status_i, pass_o, err_o});

  always_comb begin
    if (known_c) begin
      p_excl_r11: assert (!(pass_o && err_o));
      if (half_mode_i && !is_branch_i)
        p_nonbr_pass_r10: assert (pass_o && !err_o);
      if ((!half_mode_i || is_branch_i) && code_c == 4'd14)
        p_always_r6: assert (pass_o && !err_o);
      if ((!half_mode_i || is_branch_i) && code_c == 4'd15)
        p_rsv_err_r7: assert (err_o && !pass_o);
      if ((!half_mode_i || is_branch_i) && code_c != 4'd15)
        p_no_err_r7: assert (!err_o);
    end
  end
endmodule

bind cond_gate cond_gate_chk #(.INSTR_W(INSTR_W), .STATUS_W(STATUS_W)) u_chk (
  .instr_i(instr_i), .half_mode_i(half_mode_i), .is_branch_i(is_branch_i),
  .status_i(status_i), .pass_o(pass_o), .err_o(err_o)
);

// File: tb/sim_cond_gate.sv
`timescale 1ns/1ps
module sim_cond_gate;
  typedef struct {
    logic  pass;
    logic  err;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0;
  logic        half = 1'b0;
  logic        br = 1'b0;
  logic [31:0] status = '0;
  logic        pass_o, err_o;
  int          checks = 0, errors = 0;
  exp_t        sb[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cond_gate u0 (
    .instr_i(instr), .half_mode_i(half), .is_branch_i(br),
    .status_i(status), .pass_o(pass_o), .err_o(err_o)
  );

  // Reference from the requirement text, code by code.
  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(input logic [3:0] c);
    if (c < 8)   return "R2";
    if (c < 10)  return "R3";
    if (c < 12)  return "R4";
    if (c < 14)  return "R5";
    if (c == 14) return "R6";
    return "R7";
  endfunction

  task automatic drive(input logic [31:0] w, input logic h, input logic b,
                       input logic [31:0] s, input string extra);
    exp_t       e;
    logic [3:0] c;
    @(posedge clk);
    #1;
    instr = w; half = h; br = b; status = s;
    c = h ? w[11:8] : w[31:28];
    if (h && !b) begin
      e.pass = 1'b1; e.err = 1'b0; e.tag = "R10";
    end else begin
      e.pass = ref_pass(c, s[31:28]);
      e.err  = (c == 4'd15);
      e.tag  = code_tag(c);
    end
    if (extra != "") e.tag = {e.tag, "/", extra};
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pass_o !== e.pass || err_o !== e.err) begin
        errors++;
        $display("FAIL %s: pass/err got %b/%b exp %b/%b (instr=%h half=%b br=%b st=%h)",
                 e.tag, pass_o, err_o, e.pass, e.err, instr, half, br, status);
      end
      checks++;
      if (pass_o === 1'b1 && err_o === 1'b1) begin
        errors++;
        $display("FAIL R11: pass/err got 1/1 exp not both high");
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // Reset/idle: all zero inputs, code EQ with Z=0.
    drive(32'h0, 1'b0, 1'b0, 32'h0, "reset");
    // R1, R8: full sweep, junk in low instr bits and low status bits, is_branch toggled.
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive({c[3:0], 28'($urandom)}, 1'b0, f[0] ^ c[0],
              {f[3:0], 28'($urandom)}, "R1/R8");
    // R9: halfword branch, junk in bits 31:16 and the rest.
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive({16'($urandom), 4'($urandom), c[3:0], 8'($urandom)}, 1'b1, 1'b1,
              {f[3:0], 28'($urandom)}, "R9");
    // R10: halfword non-branch ignores its condition.
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f += 5)
        drive({20'($urandom), c[3:0], 8'($urandom)}, 1'b1, 1'b0,
              {f[3:0], 28'h0}, "");
    // R8: top nibble 15 with valid-looking bits 11:8 in full mode.
    drive(32'hF000_0E00, 1'b0, 1'b1, 32'h0, "R8");
    drive(32'hE000_0F00, 1'b0, 1'b0, 32'h0, "R8");
    // R1: flags only from bits 31:28, lower bits all ones.
    drive(32'h0000_0000, 1'b0, 1'b0, 32'h0FFF_FFFF, "R1");
    drive(32'h8000_0000, 1'b0, 1'b0, 32'h2000_0000, "R1");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule